// File: doc/BRIEF.md
# Base-Mask Memory Type Range Matcher

This block sorts physical addresses into memory types using two programmable address ranges. All of its settings sit in one 64-bit control register. Each 32-bit half of that register describes one range. A half holds a 15-bit base, a 15-bit mask and two attribute flags. One flag marks the range as uncacheable. The other marks it as write-combinable.

For every address presented with a valid strobe, the block reports two things one cycle later: whether the address is uncacheable and whether it is write-combinable. The address match itself is combinational. The result is captured in output registers together with a valid flag. Software loads the control register through a plain write-enable port and can read it back at any time.

Ranges are 128-Kbyte aligned, so only address bits [31:17] take part in the match. An all-zero mask makes a range cover the whole address space.

Top module: `mtr_range_matcher`

## Requirements
- R1: After a synchronous reset, the readback output is all zeros, and `res_valid`, `res_uc` and `res_wc` are 0.
- R2: When `cfg_we` is 1 at a clock edge, `cfg_rdata` equals `cfg_wdata` from that edge onward. Without `cfg_we`, the register holds its value.
- R3: Range 0 uses register bits [31:0]: bit 0 is the uncacheable flag, bit 1 is the write-combine flag, [16:2] is the mask and [31:17] is the base. Range 1 uses the same layout in bits [63:32]. A range hits when (mask AND base) equals (mask AND addr[31:17]).
- R4: A hitting range with its uncacheable flag set gives `res_uc`=1 and `res_wc`=0, whatever its write-combine flag holds.
- R5: A hitting range with uncacheable flag 0 and write-combine flag 1 gives `res_wc`=1 and `res_uc`=1.
- R6: A hitting range with both flags 0, and any range that does not hit, contributes nothing. With no contribution from either range, `res_uc`=0 and `res_wc`=0.
- R7: With both ranges contributing, `res_uc` is 1 if either range contributes. `res_wc` is 1 only if some range is write-combining and neither range is plain uncacheable.
- R8: Address bits [16:0] never affect the result.
- R9: A range with an all-zero mask hits every address.
- R10: A lookup accepted with `addr_valid`=1 at an edge shows its result and `res_valid`=1 right after that edge. `res_valid` is 0 after an edge with `addr_valid`=0, and the result bits then hold their values.
- R11: A lookup and a register write at the same edge use the register contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write enable for the control register |
| cfg_wdata | input | 64 | New control register value |
| cfg_rdata | output | 64 | Current control register value |
| addr_valid | input | 1 | Address strobe |
| addr | input | 32 | Physical address to classify |
| res_valid | output | 1 | Result valid, one cycle after the strobe |
| res_uc | output | 1 | Address is uncacheable |
| res_wc | output | 1 | Address is write-combinable |

## Verification
Directed lookups come first. They cover each of the four flag pairs on a single hitting range, which separates plain uncacheable, write-combining and no-effect results. They also cover a miss next to a hit, the all-zero mask, and address pairs that differ only in their low 17 bits. Further directed cases enable both ranges with conflicting flags to expose the precedence rule, and place a write and a lookup at the same edge to show which register value the lookup uses. Random register contents and addresses follow, with about half the addresses built from a range's base so that hits are frequent, and random idle cycles to check valid timing and result holding.

// File: rtl/mtr_pkg.sv
package mtr_pkg;

    localparam int ADDR_W     = 32;
    localparam int LOW_W      = 17;
    localparam int FIELD_W    = ADDR_W - LOW_W;
    localparam int SLOT_W     = 2 + 2 * FIELD_W;
    localparam int NUM_RANGES = 2;
    localparam int CFG_W      = NUM_RANGES * SLOT_W;

    typedef logic [FIELD_W-1:0] tag_t;

    // Packed MSB first: base at the top, uncacheable flag at bit 0.
    typedef struct packed {
        tag_t base;
        tag_t mask;
        logic wc;
        logic uc;
    } slot_t;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_WC   = 2'd1,
        KIND_UC   = 2'd2
    } kind_t;

    typedef struct packed {
        logic uc;
        logic wc;
    } attr_t;

    function automatic logic slot_hit(slot_t s, tag_t tag);
        return (s.mask & s.base) == (s.mask & tag);
    endfunction

    function automatic kind_t slot_kind(slot_t s, tag_t tag);
        if (!slot_hit(s, tag)) return KIND_NONE;
        if (s.uc)              return KIND_UC;
        if (s.wc)              return KIND_WC;
        return KIND_NONE;
    endfunction

endpackage

// File: rtl/mtr_cfg_reg.sv
module mtr_cfg_reg
    import mtr_pkg::*;
#(
    parameter int W = CFG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (we) q <= wdata;
    end

    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (rst)
        we |=> (q == $past(wdata)));                               // R2
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));                                       // R2

endmodule

// File: rtl/mtr_slot_match.sv
module mtr_slot_match
    import mtr_pkg::*;
(
    input  slot_t slot,
    input  tag_t  tag,
    output kind_t kind
);

    always_comb kind = slot_kind(slot, tag);

    always_comb begin
        if (slot.mask == '0)
            AST_ZERO_MASK_HIT: assert (slot_hit(slot, tag) || $isunknown(tag)); // R9
    end

endmodule

// File: rtl/mtr_merge.sv
module mtr_merge
    import mtr_pkg::*;
#(
    parameter int N = NUM_RANGES
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  kind_t kinds [N],
    output logic  out_valid,
    output attr_t out_attr
);

    logic  any_uc;
    logic  any_wc;
    attr_t next_attr;

    always_comb begin
        any_uc = 1'b0;
        any_wc = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (kinds[i] == KIND_UC) any_uc = 1'b1;
            if (kinds[i] == KIND_WC) any_wc = 1'b1;
        end
        next_attr.uc = any_uc | any_wc;
        next_attr.wc = any_wc & ~any_uc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_attr  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_attr <= next_attr;
        end
    end

    AST_WC_IMPLIES_UC: assert property (@(posedge clk) disable iff (rst)
        out_attr.wc |-> out_attr.uc);                              // R5
    AST_UC_WINS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && any_uc) |=> (out_attr.uc && !out_attr.wc));   // R4
    AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);                                   // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_attr)));          // R10

endmodule

// File: rtl/mtr_range_matcher.sv
module mtr_range_matcher
    import mtr_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int CW = CFG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [CW-1:0] cfg_wdata,
    output logic [CW-1:0] cfg_rdata,
    input  logic          addr_valid,
    input  logic [AW-1:0] addr,
    output logic          res_valid,
    output logic          res_uc,
    output logic          res_wc
);

    logic [CW-1:0] cfg_q;
    tag_t          tag;
    kind_t         kinds [NUM_RANGES];
    attr_t         attr;

    assign tag = addr[AW-1 -: FIELD_W];

    mtr_cfg_reg #(.W(CW)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .q     (cfg_q)
    );

    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_slot
        mtr_slot_match u_match (
            .slot (slot_t'(cfg_q[g*SLOT_W +: SLOT_W])),
            .tag  (tag),
            .kind (kinds[g])
        );
    end

    mtr_merge #(.N(NUM_RANGES)) u_merge (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (addr_valid),
        .kinds     (kinds),
        .out_valid (res_valid),
        .out_attr  (attr)
    );

    assign cfg_rdata = cfg_q;
    assign res_uc    = attr.uc;
    assign res_wc    = attr.wc;

    AST_SAME_TAG_SAME_RESULT: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && $past(addr_valid) && tag == $past(tag) && !$past(cfg_we))
        |=> ($stable(res_uc) && $stable(res_wc)));                 // R8

endmodule

// File: tb/sim_mtr_range_matcher.sv
module sim_mtr_range_matcher;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [63:0] cfg_wdata;
    logic [63:0] cfg_rdata;
    logic        addr_valid;
    logic [31:0] addr;
    logic        res_valid, res_uc, res_wc;

    int checks = 0;
    int fails  = 0;
    logic [63:0] model_cfg;

    always #(CLK_PERIOD/2) clk = ~clk;

    mtr_range_matcher u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .addr_valid(addr_valid), .addr(addr),
        .res_valid(res_valid), .res_uc(res_uc), .res_wc(res_wc)
    );

    // Reference: 2-bit result {uc, wc}
    function automatic logic [1:0] ref_attr(logic [63:0] c, logic [31:0] a);
        logic pure_uc = 1'b0;
        logic wcomb   = 1'b0;
        for (int r = 0; r < 2; r++) begin
            logic [31:0] s = c[r*32 +: 32];
            logic [14:0] b = s[31:17];
            logic [14:0] m = s[16:2];
            if ((m & b) == (m & a[31:17])) begin
                if (s[0])      pure_uc = 1'b1;
                else if (s[1]) wcomb   = 1'b1;
            end
        end
        return {pure_uc | wcomb, wcomb & ~pure_uc};
    endfunction

    function automatic logic [31:0] mk(logic [14:0] b, logic [14:0] m, logic wc, logic uc);
        return {b, m, wc, uc};
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_cfg(logic [63:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v; addr_valid = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0;
        model_cfg = v;
    endtask

    task automatic lookup(string req, logic [31:0] a);
        logic [1:0] e;
        @(negedge clk);
        addr_valid = 1'b1; addr = a;
        e = ref_attr(model_cfg, a);
        @(negedge clk);
        addr_valid = 1'b0;
        check(req, {61'd0, res_valid, res_uc, res_wc}, {61'd0, 1'b1, e});
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [1:0] held;
        void'($urandom(32'd4242));
        rst = 1'b1; cfg_we = 1'b0; cfg_wdata = '0; addr_valid = 1'b0; addr = '0;
        model_cfg = '0;
        repeat (3) @(negedge clk);
        check("R1 rdata", cfg_rdata, 64'd0);
        check("R1 res", {61'd0, res_valid, res_uc, res_wc}, 64'd0);
        rst = 1'b0;
        lookup("R9 reset no-effect", 32'h1234_5678);

        write_cfg({32'd0, mk(15'h0040, 15'h7FC0, 1'b0, 1'b1)});
        check("R2 readback", cfg_rdata, model_cfg);
        lookup("R4 uc hit", 32'h0080_0000);
        check("R4 exact", {62'd0, res_uc, res_wc}, 64'd2);
        lookup("R3 miss", 32'h0100_0000);
        check("R6 miss exact", {62'd0, res_uc, res_wc}, 64'd0);
        lookup("R8 low bits", 32'h0081_FFFF);

        write_cfg({32'd0, mk(15'h0040, 15'h7FC0, 1'b1, 1'b1)});
        lookup("R4 uc+wc", 32'h0080_1234);
        write_cfg({32'd0, mk(15'h0040, 15'h7FC0, 1'b1, 1'b0)});
        lookup("R5 wc hit", 32'h0080_0000);
        check("R5 exact", {62'd0, res_uc, res_wc}, 64'd3);
        write_cfg({32'd0, mk(15'h0040, 15'h7FC0, 1'b0, 1'b0)});
        lookup("R6 no flags", 32'h0080_0000);
        check("R6 exact", {62'd0, res_uc, res_wc}, 64'd0);

        write_cfg({mk(15'h0, 15'h0, 1'b1, 1'b0), 32'd0});
        lookup("R9 zero mask", 32'hFFFF_FFFF);
        check("R9 exact", {62'd0, res_uc, res_wc}, 64'd3);

        write_cfg({mk(15'h0, 15'h0, 1'b1, 1'b0), mk(15'h7FFF, 15'h7FFF, 1'b0, 1'b1)});
        lookup("R7 wc vs uc", 32'hFFFE_0000);
        check("R7 exact", {62'd0, res_uc, res_wc}, 64'd2);
        lookup("R7 wc only", 32'h0000_0000);
        check("R7 wc exact", {62'd0, res_uc, res_wc}, 64'd3);

        // R10: idle cycle drops valid and holds result
        held = {res_uc, res_wc};
        @(negedge clk);
        check("R10 idle", {61'd0, res_valid, res_uc, res_wc}, {61'd0, 1'b0, held});

        // R11: same-edge write and lookup
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = 64'd0; addr_valid = 1'b1; addr = 32'h0000_0000;
        @(negedge clk);
        cfg_we = 1'b0; addr_valid = 1'b0;
        check("R11 old value", {62'd0, res_uc, res_wc}, {62'd0, ref_attr(model_cfg, 32'h0)});
        model_cfg = 64'd0;
        check("R11 new readback", cfg_rdata, 64'd0);

        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 7) == 0)
                write_cfg({$urandom(), $urandom()});
            if ($urandom_range(0, 1) == 0) begin
                int r = $urandom_range(0, 1);
                logic [31:0] s = model_cfg[r*32 +: 32];
                logic [31:0] a = $urandom();
                a[31:17] = (s[31:17] & s[16:2]) | (a[31:17] & ~s[16:2]);
                lookup("R3 random hit", a);
            end else begin
                lookup("R7 random", $urandom());
            end
            if ($urandom_range(0, 3) == 0) begin
                held = {res_uc, res_wc};
                @(negedge clk);
                check("R10 random idle", {61'd0, res_valid, res_uc, res_wc}, {61'd0, 1'b0, held});
            end
        end
        check("R2 final readback", cfg_rdata, model_cfg);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule